// File: doc/BRIEF.md
# Multi-width Integer ALU

A combinational integer execution unit for a 64-bit register machine. Each evaluation takes an 8-bit decoded opcode and two 64-bit operands. The second operand may come from a register or from an immediate that was already widened upstream. The unit returns one 64-bit result in the same evaluation. It covers wrapping add, subtract and multiply at four widths, full-width bitwise logic, three shift kinds at four widths, three-way compare, complement, logical negation and sign extension.

An operation narrower than 64 bits works on the low bits of its operands. Its result is zero-extended into the upper register bits. The register-immediate opcodes reach the same datapath as their register-register counterparts. An opcode the unit does not recognise raises a flag and forces the result to zero.

Top module: `int_alu`

## Requirements
- R1: Opcodes 0x03, 0x04, 0x05 and 0x06 add opa_i and opb_i modulo 2^8, 2^16, 2^32 and 2^64, in that order. A narrow sum is zero-extended into result_o.
- R2: Opcodes 0x07 to 0x0A compute opa_i minus opb_i with wrap-around. The widths and the zero extension follow R1.
- R3: Opcodes 0x0B to 0x0E return the low 8, 16, 32 or 64 bits of the product of the low operand bits. The result is zero-extended.
- R4: Opcodes 0x0F, 0x10 and 0x11 return the 64-bit AND, OR and XOR of the operands.
- R5: Each shift uses an amount equal to opb_i modulo the width W, and its result is zero-extended above W.
  - Opcodes 0x12 to 0x15 shift left logically, with W = 8, 16, 32, 64.
  - Opcodes 0x16 to 0x19 shift right logically over the same widths.
  - Opcodes 0x1A to 0x1D shift right arithmetically over the same widths, filling from bit W-1 of opa_i.
- R6: Opcode 0x1E compares the operands as unsigned 64-bit values and 0x1F as signed. Each writes all ones when opa_i < opb_i, zero when they are equal and 1 when opa_i > opb_i.
- R7: Opcode 0x28 returns the bitwise complement of opa_i. Opcode 0x29 returns 1 when opa_i is zero and 0 otherwise.
- R8: Opcodes 0x2A, 0x2B and 0x2C return bits 7:0, 15:0 and 31:0 of opa_i sign-extended to 64 bits.
- R9: The immediate opcodes give the same result as their register counterparts. 0x2D to 0x30 act as 0x03 to 0x06. 0x31 to 0x34 act as 0x0B to 0x0E. 0x35 to 0x37 act as 0x0F to 0x11. 0x38 to 0x43 act as 0x12 to 0x1D. 0x44 and 0x45 act as 0x1E and 0x1F.
- R10: Every opcode not listed in R1 to R9 drives illegal_o high and result_o to zero. Every listed opcode drives illegal_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 8 | Decoded operation code |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand, from a register or an immediate |
| result_o | output | 64 | Operation result |
| illegal_o | output | 1 | Opcode not recognised |

## Verification
The bench builds the unit with the default 64-bit data width, so all four lane widths exist. At 8 bits the operand space is small enough for an exhaustive sweep. Every pair of low bytes is applied to the 8-bit add, subtract, multiply and three shifts, with random upper operand bits so that zero extension and masking of the shift amount are exercised. All 256 opcode values are then swept with random operands, which reaches the immediate aliases, the wider lanes and every unrecognised code. Directed vectors cover the compare edges at the signed and unsigned extremes, negation of zero, sign-extension boundaries and shift amounts of W-1, W and 2W-1.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [3:0] {
    CL_NONE, CL_ADD, CL_SUB, CL_MUL, CL_AND, CL_OR, CL_XOR,
    CL_SLL, CL_SRL, CL_SRA, CL_CMPU, CL_CMPS, CL_CPL, CL_LNOT, CL_SEXT
  } op_class_e;

  typedef struct packed {
    op_class_e  cls;
    logic [1:0] wsel;  // 0:8b 1:16b 2:32b 3:64b
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic [7:0] op);
    op_dec_t d;
    d.cls  = CL_NONE;
    d.wsel = op[1:0];
    if (op inside {[8'h03:8'h06]})      begin d.cls = CL_ADD;  d.wsel = 2'(op - 8'h03); end
    else if (op inside {[8'h07:8'h0A]}) begin d.cls = CL_SUB;  d.wsel = 2'(op - 8'h07); end
    else if (op inside {[8'h0B:8'h0E]}) begin d.cls = CL_MUL;  d.wsel = 2'(op - 8'h0B); end
    else if (op == 8'h0F || op == 8'h35) d.cls = CL_AND;
    else if (op == 8'h10 || op == 8'h36) d.cls = CL_OR;
    else if (op == 8'h11 || op == 8'h37) d.cls = CL_XOR;
    else if (op inside {[8'h12:8'h15]}) begin d.cls = CL_SLL;  d.wsel = 2'(op - 8'h12); end
    else if (op inside {[8'h16:8'h19]}) begin d.cls = CL_SRL;  d.wsel = 2'(op - 8'h16); end
    else if (op inside {[8'h1A:8'h1D]}) begin d.cls = CL_SRA;  d.wsel = 2'(op - 8'h1A); end
    else if (op == 8'h1E || op == 8'h44) d.cls = CL_CMPU;
    else if (op == 8'h1F || op == 8'h45) d.cls = CL_CMPS;
    else if (op == 8'h28) d.cls = CL_CPL;
    else if (op == 8'h29) d.cls = CL_LNOT;
    else if (op inside {[8'h2A:8'h2C]}) begin d.cls = CL_SEXT; d.wsel = 2'(op - 8'h2A); end
    else if (op inside {[8'h2D:8'h30]}) begin d.cls = CL_ADD;  d.wsel = 2'(op - 8'h2D); end
    else if (op inside {[8'h31:8'h34]}) begin d.cls = CL_MUL;  d.wsel = 2'(op - 8'h31); end
    else if (op inside {[8'h38:8'h3B]}) begin d.cls = CL_SLL;  d.wsel = 2'(op - 8'h38); end
    else if (op inside {[8'h3C:8'h3F]}) begin d.cls = CL_SRL;  d.wsel = 2'(op - 8'h3C); end
    else if (op inside {[8'h40:8'h43]}) begin d.cls = CL_SRA;  d.wsel = 2'(op - 8'h40); end
    return d;
  endfunction

endpackage

// File: rtl/int_alu_arith.sv
module int_alu_arith #(
  parameter int XLEN = 64
) (
  input  logic [1:0]      wsel_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] add_o,
  output logic [XLEN-1:0] sub_o,
  output logic [XLEN-1:0] mul_o
);
  localparam int NLANE = 4;

  logic [XLEN-1:0] add_l [NLANE];
  logic [XLEN-1:0] sub_l [NLANE];
  logic [XLEN-1:0] mul_l [NLANE];

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam int LW = XLEN >> (NLANE - 1 - i);
    logic [LW-1:0] s, d, p;
    assign s = a_i[LW-1:0] + b_i[LW-1:0];
    assign d = a_i[LW-1:0] - b_i[LW-1:0];
    assign p = a_i[LW-1:0] * b_i[LW-1:0];
    assign add_l[i] = XLEN'(s);
    assign sub_l[i] = XLEN'(d);
    assign mul_l[i] = XLEN'(p);

    // R2
    always_comb begin
      sub_inverse_chk: assert (LW'(d + b_i[LW-1:0]) == a_i[LW-1:0]);
    end
  end

  assign add_o = add_l[wsel_i];
  assign sub_o = sub_l[wsel_i];
  assign mul_o = mul_l[wsel_i];
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
  parameter int XLEN = 64
) (
  input  logic [1:0]      wsel_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] sll_o,
  output logic [XLEN-1:0] srl_o,
  output logic [XLEN-1:0] sra_o
);
  localparam int NLANE = 4;

  logic [XLEN-1:0] sll_l [NLANE];
  logic [XLEN-1:0] srl_l [NLANE];
  logic [XLEN-1:0] sra_l [NLANE];

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam int LW  = XLEN >> (NLANE - 1 - i);
    localparam int SHW = $clog2(LW);
    logic [SHW-1:0] amt;
    logic [LW-1:0]  l, r, ar;
    assign amt = b_i[SHW-1:0];  // amount modulo lane width
    assign l   = a_i[LW-1:0] << amt;
    assign r   = a_i[LW-1:0] >> amt;
    assign ar  = LW'($signed(a_i[LW-1:0]) >>> amt);
    assign sll_l[i] = XLEN'(l);
    assign srl_l[i] = XLEN'(r);
    assign sra_l[i] = XLEN'(ar);

    // R5
    always_comb begin
      sra_fill_chk: assert (ar[LW-1] == a_i[LW-1]);
    end
  end

  assign sll_o = sll_l[wsel_i];
  assign srl_o = srl_l[wsel_i];
  assign sra_o = sra_l[wsel_i];
endmodule

// File: rtl/int_alu_misc.sv
module int_alu_misc #(
  parameter int XLEN = 64
) (
  input  logic [1:0]      wsel_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] and_o,
  output logic [XLEN-1:0] or_o,
  output logic [XLEN-1:0] xor_o,
  output logic [XLEN-1:0] cmpu_o,
  output logic [XLEN-1:0] cmps_o,
  output logic [XLEN-1:0] cpl_o,
  output logic [XLEN-1:0] lnot_o,
  output logic [XLEN-1:0] sext_o
);
  localparam logic [XLEN-1:0] MINUS1 = '1;
  localparam logic [XLEN-1:0] PLUS1  = XLEN'(1);

  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
  assign xor_o = a_i ^ b_i;
  assign cpl_o = ~a_i;
  assign lnot_o = XLEN'(a_i == '0);

  assign cmpu_o = (a_i < b_i) ? MINUS1 : (a_i == b_i) ? '0 : PLUS1;
  assign cmps_o = ($signed(a_i) < $signed(b_i)) ? MINUS1 : (a_i == b_i) ? '0 : PLUS1;

  always_comb begin
    unique case (wsel_i)
      2'd0:    sext_o = XLEN'($signed(a_i[7:0]));
      2'd1:    sext_o = XLEN'($signed(a_i[15:0]));
      2'd2:    sext_o = XLEN'($signed(a_i[31:0]));
      default: sext_o = a_i;
    endcase
  end

  // R6
  always_comb begin
    cmp_equal_chk: assert ((cmpu_o == '0) == (cmps_o == '0));
  end
endmodule

// File: rtl/int_alu.sv
module int_alu #(
  parameter int XLEN = 64
) (
  input  logic [7:0]      opcode_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);
  import int_alu_pkg::*;

  op_dec_t dec;
  logic [XLEN-1:0] add_r, sub_r, mul_r, sll_r, srl_r, sra_r;
  logic [XLEN-1:0] and_r, or_r, xor_r, cmpu_r, cmps_r, cpl_r, lnot_r, sext_r;

  assign dec = decode_op(opcode_i);

  int_alu_arith #(.XLEN(XLEN)) u_arith (
    .wsel_i(dec.wsel), .a_i(opa_i), .b_i(opb_i),
    .add_o(add_r), .sub_o(sub_r), .mul_o(mul_r)
  );

  int_alu_shift #(.XLEN(XLEN)) u_shift (
    .wsel_i(dec.wsel), .a_i(opa_i), .b_i(opb_i),
    .sll_o(sll_r), .srl_o(srl_r), .sra_o(sra_r)
  );

  int_alu_misc #(.XLEN(XLEN)) u_misc (
    .wsel_i(dec.wsel), .a_i(opa_i), .b_i(opb_i),
    .and_o(and_r), .or_o(or_r), .xor_o(xor_r),
    .cmpu_o(cmpu_r), .cmps_o(cmps_r), .cpl_o(cpl_r),
    .lnot_o(lnot_r), .sext_o(sext_r)
  );

  always_comb begin
    illegal_o = 1'b0;
    unique case (dec.cls)
      CL_ADD:  result_o = add_r;
      CL_SUB:  result_o = sub_r;
      CL_MUL:  result_o = mul_r;
      CL_AND:  result_o = and_r;
      CL_OR:   result_o = or_r;
      CL_XOR:  result_o = xor_r;
      CL_SLL:  result_o = sll_r;
      CL_SRL:  result_o = srl_r;
      CL_SRA:  result_o = sra_r;
      CL_CMPU: result_o = cmpu_r;
      CL_CMPS: result_o = cmps_r;
      CL_CPL:  result_o = cpl_r;
      CL_LNOT: result_o = lnot_r;
      CL_SEXT: result_o = sext_r;
      default: begin
        result_o  = '0;
        illegal_o = 1'b1;
      end
    endcase
  end

  logic narrow_op;
  assign narrow_op = (dec.cls inside {CL_ADD, CL_SUB, CL_MUL, CL_SLL, CL_SRL, CL_SRA})
                     && dec.wsel != 2'd3;

  always_comb begin
    // R10
    illegal_zero_chk: assert (!illegal_o || result_o == '0);
    // R6
    if (dec.cls inside {CL_CMPU, CL_CMPS})
      cmp_range_chk: assert (result_o == '0 || result_o == XLEN'(1) || result_o == '1);
    // R7
    if (dec.cls == CL_LNOT)
      lnot_bool_chk: assert (result_o[XLEN-1:1] == '0 && (result_o[0] != (|opa_i)));
    // R1
    if (narrow_op)
      narrow_upper_chk: assert (result_o[XLEN-1:XLEN/2] == '0);
    // R8
    if (dec.cls == CL_SEXT)
      sext_upper_chk: assert (result_o[XLEN-1:XLEN/2] == '0 || result_o[XLEN-1:XLEN/2] == '1);
  end
endmodule

// File: tb/int_alu_tb.sv
module int_alu_tb;
  logic        clk = 1'b0;
  logic [7:0]  opcode;
  logic [63:0] opa, opb, result;
  logic        illegal;
  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  int_alu u_dut (
    .opcode_i(opcode), .opa_i(opa), .opb_i(opb),
    .result_o(result), .illegal_o(illegal)
  );

  function automatic logic [63:0] msk(input logic [63:0] x, input int w);
    return (w == 64) ? x : (x & ((64'd1 << w) - 64'd1));
  endfunction

  // canonical register opcode for an immediate alias
  function automatic logic [7:0] canon(input logic [7:0] op);
    if (op >= 8'h2D && op <= 8'h30) return op - 8'h2A;
    if (op >= 8'h31 && op <= 8'h45) return op - 8'h26;
    return op;
  endfunction

  function automatic string req_of(input logic [7:0] op_in);
    logic [7:0] op = canon(op_in);
    if (op_in >= 8'h2D && op_in <= 8'h45) return "R9";
    if (op >= 8'h03 && op <= 8'h06) return "R1";
    if (op >= 8'h07 && op <= 8'h0A) return "R2";
    if (op >= 8'h0B && op <= 8'h0E) return "R3";
    if (op >= 8'h0F && op <= 8'h11) return "R4";
    if (op >= 8'h12 && op <= 8'h1D) return "R5";
    if (op == 8'h1E || op == 8'h1F) return "R6";
    if (op == 8'h28 || op == 8'h29) return "R7";
    if (op >= 8'h2A && op <= 8'h2C) return "R8";
    return "R10";
  endfunction

  function automatic logic [64:0] model(input logic [7:0] op_in, input logic [63:0] a, b);
    logic [7:0] op = canon(op_in);
    int w;
    logic [63:0] ax, r;
    int amt;
    if (op >= 8'h03 && op <= 8'h0E) begin
      w = 8 << ((op - 8'h03) % 4);
      if (op <= 8'h06)      r = msk(a + b, w);
      else if (op <= 8'h0A) r = msk(a - b, w);
      else                  r = msk(msk(a, w) * msk(b, w), w);
      return {1'b0, r};
    end
    if (op == 8'h0F) return {1'b0, a & b};
    if (op == 8'h10) return {1'b0, a | b};
    if (op == 8'h11) return {1'b0, a ^ b};
    if (op >= 8'h12 && op <= 8'h1D) begin
      w = 8 << ((op - 8'h12) % 4);
      amt = int'(b % 64'(w));
      ax = msk(a, w);
      if (op <= 8'h15)      r = msk(ax << amt, w);
      else if (op <= 8'h19) r = ax >> amt;
      else begin
        if (ax[w-1]) ax = ax | ~msk('1, w);
        r = msk(64'($signed(ax) >>> amt), w);
      end
      return {1'b0, r};
    end
    if (op == 8'h1E) return {1'b0, (a < b) ? 64'hFFFF_FFFF_FFFF_FFFF : (a == b) ? 64'd0 : 64'd1};
    if (op == 8'h1F) return {1'b0, ($signed(a) < $signed(b)) ? 64'hFFFF_FFFF_FFFF_FFFF : (a == b) ? 64'd0 : 64'd1};
    if (op == 8'h28) return {1'b0, ~a};
    if (op == 8'h29) return {1'b0, (a == 0) ? 64'd1 : 64'd0};
    if (op >= 8'h2A && op <= 8'h2C) begin
      w = 8 << (op - 8'h2A);
      r = msk(a, w);
      if (r[w-1]) r = r | ~msk('1, w);
      return {1'b0, r};
    end
    return {1'b1, 64'd0};
  endfunction

  task automatic apply(input logic [7:0] op, input logic [63:0] a, b);
    logic [64:0] exp;
    opcode = op; opa = a; opb = b;
    #1;
    exp = model(op, a, b);
    n_chk++;
    if ({illegal, result} !== exp) begin
      n_err++;
      $display("FAIL %s op=%02h a=%016h b=%016h actual=%b/%016h expected=%b/%016h",
               req_of(op), op, a, b, illegal, result, exp[64], exp[63:0]);
    end
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [7:0] ops8 [6] = '{8'h03, 8'h07, 8'h0B, 8'h12, 8'h16, 8'h1A};
    logic [63:0] edges [8] = '{64'd0, 64'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
                               64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0080,
                               64'h0000_0000_8000_7F80, 64'h0000_0000_0000_FFFF};
    #3;
    // R10: idle opcode 0x00 is illegal with zero result
    apply(8'h00, 64'd0, 64'd0);

    // R1 R2 R3 R5: exhaustive 8-bit operand bytes, random upper bits
    for (int k = 0; k < 6; k++)
      for (int ia = 0; ia < 256; ia++)
        for (int ib = 0; ib < 256; ib++)
          apply(ops8[k], {$urandom, 24'($urandom), 8'(ia)}, {$urandom, 24'($urandom), 8'(ib)});

    // R9 R10 and all widths: full opcode sweep with random operands
    for (int op = 0; op < 256; op++)
      for (int n = 0; n < 48; n++)
        apply(8'(op), {$urandom, $urandom}, {$urandom, $urandom});

    // R6 R7 R8 R4: edge operand pairs over compare, unary, sign-extend, logic
    for (int op = 8'h0F; op <= 8'h2C; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(8'(op), edges[i], edges[j]);

    // R5: shift amounts at W-1, W, 2W-1 for every width
    for (int s = 0; s < 12; s++)
      for (int wi = 0; wi < 4; wi++) begin
        int w = 8 << wi;
        apply(8'(8'h12 + s), 64'h8421_8421_8421_8421, 64'(w - 1));
        apply(8'(8'h12 + s), 64'h8421_8421_8421_8421, 64'(w));
        apply(8'(8'h12 + s), 64'hF0F0_F0F0_F0F0_F0F0, 64'(2 * w - 1));
      end

    // R9: immediate aliases with edge values
    for (int op = 8'h2D; op <= 8'h45; op++)
      for (int i = 0; i < 8; i++)
        apply(8'(op), edges[i], edges[7 - i]);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule